// File: doc/BRIEF.md
# Fetch-Triggered Auto-Map Controller

This controller watches the addresses of CPU opcode fetches and pages an overlay memory into the lowest 16K of the address space when the CPU reaches certain entry points. It also pages the overlay out again when the CPU runs through a small exit window. The overlay covers two regions. The lower 8K (0x0000–0x1FFF) holds either the overlay ROM or overlay RAM bank 3. The upper 8K (0x2000–0x3FFF) holds a selectable overlay RAM bank.

Each trigger point is enabled by a configuration mask. Some triggers act at once, so the fetch that hits the trigger is served from the overlay. Other triggers are delayed: they are held until the current instruction completes and take effect from the next opcode fetch onward. A control register lets software map the overlay in by hand, choose the upper bank, and set a sticky bit that puts RAM in place of the overlay ROM. That sticky bit can only be cleared by power-on reset or while an external clear-enable input is high.

Top module: `automap_ctrl`

## Requirements
- R1: After reset, map_o, lo_ram_o and bank_o are all 0, and no map-in or unmap is pending.
- R2: A control write with bit 7 set drives map_o to 1 from the next cycle. The next write with bit 7 clear removes this manual map. While the manual map is set, no unmap trigger lowers map_o.
- R3: Every control write loads bits 3:0 into bank_o, which is visible from the next cycle.
- R4: A control write with bit 6 set sets the RAM-replace state. Once set, it stays set through later writes with bit 6 clear, unless mapram_clr_i is high during such a write. lo_ram_o equals the RAM-replace state while the manual map (bit 7) is clear, and is 0 while the manual map is set.
- R5: A trigger is recognised only in a cycle where m1_i is high. Matching addresses presented without m1_i change nothing.
- R6: A fetch at any restart vector 0x0000, 0x0008, …, 0x0038 with cfg_i[0]=1 maps the overlay in. The map-in is instant if cfg_i[1]=1 and delayed otherwise. A fetch at 0x0066 with cfg_i[2]=1 maps the overlay in, instantly if cfg_i[3]=1 and delayed otherwise.
- R7: While rom3_i=1, fetches at 0x04C6 or 0x0562 with cfg_i[4]=1, and fetches at 0x04D7 or 0x056A with cfg_i[5]=1, cause a delayed map-in. These fetches do nothing while rom3_i=0.
- R8: While rom3_i=1 and cfg_i[6]=1, a fetch in 0x3D00–0x3DFF causes an instant map-in.
- R9: With cfg_i[7]=1, a fetch in 0x1FF8–0x1FFF causes a delayed unmap.
- R10: For an instant map-in, map_o is 1 in the same cycle as the triggering fetch and stays 1 afterwards. For a delayed action, map_o changes only from the cycle after the clock edge at which instr_done_i is high. A later fetch replaces any pending action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| m1_i | input | 1 | Opcode-fetch strobe; fetch_addr_i is valid while it is high |
| fetch_addr_i | input | 16 | Fetch address |
| instr_done_i | input | 1 | Current instruction completes at this edge |
| rom3_i | input | 1 | The fourth system ROM is selected |
| cfg_i | input | 8 | Trigger enable and instant/delayed mask |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data: [7] manual map, [6] RAM replace, [3:0] bank |
| mapram_clr_i | input | 1 | Allows a write to clear the RAM-replace state |
| map_o | output | 1 | Overlay occupies 0x0000–0x3FFF |
| lo_ram_o | output | 1 | 0x0000–0x1FFF shows overlay RAM bank 3 instead of overlay ROM |
| bank_o | output | 4 | Overlay RAM bank at 0x2000–0x3FFF |

## Verification
The assertions check, on every cycle, the rules that relate one control write or one idle cycle to the next: the bank and manual map follow a write, the RAM-replace state is sticky, map_o does not move when there is no fetch, write or completion, and a mapped overlay stays mapped until an instruction completes. The bench scenarios cover what depends on the address decode and on configuration. These are each trigger class with and without its enable, the fourth-ROM qualification, instant against delayed timing around instr_done_i, and a later fetch replacing a pending action. A bench model checks random streams of fetches, writes and completions.

// File: rtl/automap_pkg.sv
package automap_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned CFG_W  = 8;

  // cfg_i bit positions
  localparam int unsigned CFG_RST_EN   = 0;
  localparam int unsigned CFG_RST_INST = 1;
  localparam int unsigned CFG_NMI_EN   = 2;
  localparam int unsigned CFG_NMI_INST = 3;
  localparam int unsigned CFG_TAPE_A   = 4;
  localparam int unsigned CFG_TAPE_B   = 5;
  localparam int unsigned CFG_PAGE3D   = 6;
  localparam int unsigned CFG_UNMAP    = 7;

  // control register bit positions
  localparam int unsigned CTL_MANUAL = 7;
  localparam int unsigned CTL_RAMREP = 6;

  localparam logic [ADDR_W-1:0] NMI_VEC    = 16'h0066;
  localparam logic [ADDR_W-1:0] TAPE_A_LD  = 16'h04C6;
  localparam logic [ADDR_W-1:0] TAPE_A_SV  = 16'h0562;
  localparam logic [ADDR_W-1:0] TAPE_B_LD  = 16'h04D7;
  localparam logic [ADDR_W-1:0] TAPE_B_SV  = 16'h056A;
  localparam logic [7:0]        PAGE3D_HI  = 8'h3D;
  localparam logic [ADDR_W-4:0] UNMAP_WIN  = 13'h03FF; // 0x1FF8 >> 3

  typedef struct packed {
    logic instant;
    logic dly_map;
    logic dly_unmap;
  } trig_t;
endpackage

// File: rtl/automap_decode.sv
module automap_decode
  import automap_pkg::*;
#(
  parameter int unsigned VEC_STEP = 8,
  parameter int unsigned VEC_LAST = 56
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              m1_i,
  input  logic              rom3_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output trig_t             trig_o
);
  localparam int unsigned N_VEC = VEC_LAST / VEC_STEP + 1;

  logic [N_VEC-1:0] vec_hit;
  for (genvar g = 0; g < N_VEC; g++) begin : g_vec
    assign vec_hit[g] = (addr_i == ADDR_W'(g * VEC_STEP));
  end

  logic rst_hit, nmi_hit, tape_hit, pg3d_hit, unmap_hit;
  always_comb begin
    rst_hit   = (|vec_hit) && cfg_i[CFG_RST_EN];
    nmi_hit   = (addr_i == NMI_VEC) && cfg_i[CFG_NMI_EN];
    tape_hit  = rom3_i && (
                  (cfg_i[CFG_TAPE_A] && (addr_i == TAPE_A_LD || addr_i == TAPE_A_SV)) ||
                  (cfg_i[CFG_TAPE_B] && (addr_i == TAPE_B_LD || addr_i == TAPE_B_SV)));
    pg3d_hit  = rom3_i && cfg_i[CFG_PAGE3D] && (addr_i[ADDR_W-1:8] == PAGE3D_HI);
    unmap_hit = cfg_i[CFG_UNMAP] && (addr_i[ADDR_W-1:3] == UNMAP_WIN);

    trig_o.instant   = m1_i && ((rst_hit && cfg_i[CFG_RST_INST]) ||
                                (nmi_hit && cfg_i[CFG_NMI_INST]) || pg3d_hit);
    trig_o.dly_map   = m1_i && ((rst_hit && !cfg_i[CFG_RST_INST]) ||
                                (nmi_hit && !cfg_i[CFG_NMI_INST]) || tape_hit);
    trig_o.dly_unmap = m1_i && unmap_hit;
  end
endmodule

// File: rtl/automap_seq.sv
module automap_seq
  import automap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  m1_i,
  input  logic  instr_done_i,
  input  trig_t trig_i,
  output logic  auto_o
);
  logic auto_q, pend_map_q, pend_unmap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q       <= 1'b0;
      pend_map_q   <= 1'b0;
      pend_unmap_q <= 1'b0;
    end else begin
      if (instr_done_i) begin
        if (pend_map_q)   auto_q <= 1'b1;
        if (pend_unmap_q) auto_q <= 1'b0;
        pend_map_q   <= 1'b0;
        pend_unmap_q <= 1'b0;
      end
      // a new fetch overrides any pending action
      if (m1_i) begin
        if (trig_i.instant) auto_q <= 1'b1;
        pend_map_q   <= trig_i.dly_map;
        pend_unmap_q <= trig_i.dly_unmap;
      end
    end
  end

  assign auto_o = auto_q;
endmodule

// File: rtl/automap_ctlreg.sv
module automap_ctlreg
  import automap_pkg::*;
#(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTL_W-1:0]  wdata_i,
  input  logic              clr_en_i,
  output logic              manual_o,
  output logic              ramrep_o,
  output logic [BANK_W-1:0] bank_o
);
  logic              manual_q, ramrep_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      manual_q <= 1'b0;
      ramrep_q <= 1'b0;
      bank_q   <= '0;
    end else if (we_i) begin
      manual_q <= wdata_i[CTL_MANUAL];
      bank_q   <= wdata_i[BANK_W-1:0];
      ramrep_q <= wdata_i[CTL_RAMREP] || (ramrep_q && !clr_en_i);
    end
  end

  logic unused_bits;
  assign unused_bits = ^wdata_i[CTL_RAMREP-1:BANK_W];

  assign manual_o = manual_q;
  assign ramrep_o = ramrep_q;
  assign bank_o   = bank_q;
endmodule

// File: rtl/automap_ctrl.sv
module automap_ctrl
  import automap_pkg::*;
#(
  parameter int unsigned BANK_W   = 4,
  parameter int unsigned VEC_STEP = 8,
  parameter int unsigned VEC_LAST = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m1_i,
  input  logic [15:0]       fetch_addr_i,
  input  logic              instr_done_i,
  input  logic              rom3_i,
  input  logic [7:0]        cfg_i,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic              mapram_clr_i,
  output logic              map_o,
  output logic              lo_ram_o,
  output logic [BANK_W-1:0] bank_o
);
  trig_t trig;
  logic  auto_map, manual, ramrep;

  automap_decode #(.VEC_STEP(VEC_STEP), .VEC_LAST(VEC_LAST)) i_decode (
    .addr_i (fetch_addr_i),
    .m1_i   (m1_i),
    .rom3_i (rom3_i),
    .cfg_i  (cfg_i),
    .trig_o (trig)
  );

  automap_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .m1_i         (m1_i),
    .instr_done_i (instr_done_i),
    .trig_i       (trig),
    .auto_o       (auto_map)
  );

  automap_ctlreg #(.BANK_W(BANK_W)) i_ctlreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .wdata_i  (ctl_wdata_i),
    .clr_en_i (mapram_clr_i),
    .manual_o (manual),
    .ramrep_o (ramrep),
    .bank_o   (bank_o)
  );

  // instant trigger serves the triggering fetch itself
  assign map_o    = manual || auto_map || trig.instant;
  assign lo_ram_o = ramrep && !manual;
endmodule

// File: rtl/automap_chk.sv
module automap_chk #(
  parameter int unsigned BANK_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              m1_i,
  input logic              instr_done_i,
  input logic              ctl_we_i,
  input logic [7:0]        ctl_wdata_i,
  input logic              mapram_clr_i,
  input logic              map_o,
  input logic              lo_ram_o,
  input logic [BANK_W-1:0] bank_o
);
  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> bank_o == $past(ctl_wdata_i[BANK_W-1:0])); // R3

  AST_MANUAL_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[7]) |=> map_o); // R2

  AST_RAMREP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_ram_o && ctl_we_i && !ctl_wdata_i[7] && !mapram_clr_i) |=> lo_ram_o); // R4

  AST_RAMREP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(lo_ram_o)); // R4

  AST_NO_FETCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1_i && !ctl_we_i && !instr_done_i) |=> (m1_i || $stable(map_o))); // R5

  AST_MAP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_o && !ctl_we_i && !instr_done_i) |=> map_o); // R10
endmodule

bind automap_ctrl automap_chk #(.BANK_W(BANK_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .m1_i         (m1_i),
  .instr_done_i (instr_done_i),
  .ctl_we_i     (ctl_we_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .mapram_clr_i (mapram_clr_i),
  .map_o        (map_o),
  .lo_ram_o     (lo_ram_o),
  .bank_o       (bank_o)
);

// File: tb/test_automap_ctrl.sv
module test_automap_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m1_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        instr_done_i = 1'b0;
  logic        rom3_i = 1'b0;
  logic [7:0]  cfg_i = '0;
  logic        ctl_we_i = 1'b0;
  logic [7:0]  ctl_wdata_i = '0;
  logic        mapram_clr_i = 1'b0;
  logic        map_o, lo_ram_o;
  logic [3:0]  bank_o;

  always #2 clk_i = ~clk_i;

  automap_ctrl i_automap_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_man, m_rep, m_auto, m_pmap, m_punmap;
  bit [3:0] m_bank;

  // returns {instant, delayed map, delayed unmap}
  function automatic bit [2:0] ref_trig(bit m1, bit [15:0] a, bit r3, bit [7:0] c);
    bit [2:0] t = 3'b000;
    if (!m1) return t;
    if (a <= 16'h0038 && a[2:0] == 3'b000 && c[0]) t = c[1] ? 3'b100 : 3'b010;
    if (a == 16'h0066 && c[2]) t = c[3] ? 3'b100 : 3'b010;
    if (r3 && c[4] && (a == 16'h04C6 || a == 16'h0562)) t = 3'b010;
    if (r3 && c[5] && (a == 16'h04D7 || a == 16'h056A)) t = 3'b010;
    if (r3 && c[6] && a >= 16'h3D00 && a <= 16'h3DFF) t = 3'b100;
    if (c[7] && a >= 16'h1FF8 && a <= 16'h1FFF) t = 3'b001;
    return t;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit m1, bit [15:0] a, bit dn, bit r3, bit [7:0] c,
                      bit we, bit [7:0] wd, bit clr);
    bit [2:0] t;
    @(negedge clk_i);
    m1_i = m1; fetch_addr_i = a; instr_done_i = dn; rom3_i = r3; cfg_i = c;
    ctl_we_i = we; ctl_wdata_i = wd; mapram_clr_i = clr;
    #1;
    t = ref_trig(m1, a, r3, c);
    check(tag, "map_o", map_o, m_man | m_auto | t[2]);
    check(tag, "lo_ram_o", lo_ram_o, m_rep & ~m_man);
    check(tag, "bank_o", bank_o, m_bank);
    // model update at coming edge
    if (dn) begin
      if (m_pmap) m_auto = 1;
      if (m_punmap) m_auto = 0;
      m_pmap = 0; m_punmap = 0;
    end
    if (m1) begin
      if (t[2]) m_auto = 1;
      m_pmap = t[1]; m_punmap = t[0];
    end
    if (we) begin
      m_man = wd[7]; m_bank = wd[3:0];
      m_rep = wd[6] | (m_rep & ~clr);
    end
  endtask

  task automatic idle(string tag, bit [7:0] c);
    step(tag, 0, 16'h0000, 0, 0, c, 0, 8'h00, 0);
  endtask

  // fetch then instruction completion
  task automatic fetch(string tag, bit [15:0] a, bit r3, bit [7:0] c);
    step(tag, 1, a, 0, r3, c, 0, 8'h00, 0);
    step(tag, 0, a, 1, r3, c, 0, 8'h00, 0);
    idle(tag, c);
  endtask

  task automatic clear_all();
    step("R2", 0, 0, 0, 0, 8'h80, 1, 8'h00, 1);
    fetch("R9", 16'h1FFA, 0, 8'h80);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [15:0] pool [12] = '{16'h0000, 16'h0038, 16'h0018, 16'h0066, 16'h04C6, 16'h0562,
                             16'h04D7, 16'h056A, 16'h3D42, 16'h1FF8, 16'h1FFF, 16'h1234};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    #1;
    check("R1", "map_o", map_o, 0);
    check("R1", "lo_ram_o", lo_ram_o, 0);
    check("R1", "bank_o", bank_o, 0);
    rst_ni = 1'b1;
    idle("R1", 8'h00);

    // manual map and bank
    step("R2", 0, 0, 0, 0, 8'h00, 1, 8'h85, 0);
    idle("R2", 8'h00);
    step("R3", 0, 0, 0, 0, 8'h00, 1, 8'h0A, 0);
    idle("R3", 8'h00);
    // RAM replace, sticky, clear only with enable
    step("R4", 0, 0, 0, 0, 8'h00, 1, 8'h40, 0);
    idle("R4", 8'h00);
    step("R4", 0, 0, 0, 0, 8'h00, 1, 8'h03, 0);
    idle("R4", 8'h00);
    step("R4", 0, 0, 0, 0, 8'h00, 1, 8'h80, 0);
    idle("R4", 8'h00);
    step("R4", 0, 0, 0, 0, 8'h00, 1, 8'h00, 1);
    idle("R4", 8'h00);

    // no M1: no trigger
    step("R5", 0, 16'h0000, 0, 0, 8'hFF, 0, 8'h00, 0);
    step("R5", 0, 16'h0000, 1, 0, 8'hFF, 0, 8'h00, 0);
    idle("R5", 8'hFF);

    // restart vector instant, then unmap
    fetch("R6", 16'h0038, 0, 8'h83);
    idle("R6", 8'h83);
    fetch("R9", 16'h1FFC, 0, 8'h80);
    // restart vector delayed; disabled vector
    fetch("R6", 16'h0010, 0, 8'h01);
    clear_all();
    fetch("R6", 16'h0008, 0, 8'h02);
    fetch("R6", 16'h0066, 0, 8'h0C);
    clear_all();
    fetch("R6", 16'h0066, 0, 8'h04);
    clear_all();
    // tape points need rom3 and pair enable
    fetch("R7", 16'h04C6, 0, 8'h30);
    fetch("R7", 16'h04D7, 1, 8'h10);
    fetch("R7", 16'h0562, 1, 8'h10);
    clear_all();
    fetch("R7", 16'h056A, 1, 8'h20);
    clear_all();
    // 0x3Dxx instant with rom3 only
    fetch("R8", 16'h3D00, 0, 8'h40);
    fetch("R8", 16'h3DFF, 1, 8'h40);
    clear_all();
    // unmap disabled; manual map survives unmap
    fetch("R6", 16'h0000, 0, 8'h03);
    fetch("R9", 16'h1FF8, 0, 8'h00);
    step("R2", 0, 0, 0, 0, 8'h80, 1, 8'h80, 0);
    fetch("R2", 16'h1FFF, 0, 8'h80);
    clear_all();
    // later fetch replaces pending map-in
    step("R10", 1, 16'h0020, 0, 0, 8'h81, 0, 8'h00, 0);
    step("R10", 1, 16'h1234, 0, 0, 8'h81, 0, 8'h00, 0);
    step("R10", 0, 16'h0000, 1, 0, 8'h81, 0, 8'h00, 0);
    idle("R10", 8'h81);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit [3:0] op = 4'($urandom_range(0, 15));
      bit [15:0] a = ($urandom_range(0, 3) == 0) ? 16'($urandom) : pool[$urandom_range(0, 11)];
      bit [7:0] c = 8'($urandom);
      bit [7:0] wd = 8'($urandom) & 8'h7F;
      if ($urandom_range(0, 7) == 0) wd[7] = 1'b1;
      step("R10", op < 7, a, op inside {[7:11]} || op == 0, 1'($urandom), c,
           op == 12, wd, 1'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule